// File: doc/BRIEF.md
# Sticky Interrupt Flag Register with Mask Commands

This block keeps a bank of sticky interrupt flags. Each flag belongs to one hardware event source. A pulse on that source sets the flag, and the flag stays set until software removes it. Software reaches the bank through one write port. A two-bit command on that port chooses one of four operations:

- Write the interrupt enable byte.
- Clear the flags picked out by the data byte.
- Set the flags picked out by the data byte.
- Replace only the bits picked out by a mask byte with the matching bits of a value byte, in one clock.

The masked replace runs inside the block, so software never needs a read-modify-write sequence. An event that arrives while software is deciding what to write is therefore never lost. Reads return the flag byte one cycle after the request. A single interrupt line is high whenever any flag that is enabled is set.

Top module: `irq_flag_reg`

## Requirements
- R1: After reset, all flags are 0, the enable byte is 0, `rdData` is 0 and `irq` is 0.
- R2: A 1 on `hwEvent[i]` at a clock edge sets flag i. The flag stays 1 until a software command removes it.
- R3: Command 2'b01 (clear) clears every flag whose `wrData` bit is 1 and leaves the rest unchanged. For example, data 8'b00100100 clears only flags 2 and 5.
- R4: Command 2'b10 (set) sets every flag whose `wrData` bit is 1 and leaves the rest unchanged.
- R5: Command 2'b11 (update) loads `(flags & ~wrMask) | (wrData & wrMask)` in a single clock.
- R6: If a hardware event and a clear or update act on the same bit in the same cycle, the event wins and the flag ends up 1.
- R7: Command 2'b00 loads `wrData` into the enable byte and leaves every flag unchanged.
- R8: `irq` is 1 exactly when `(flags & enable)` is nonzero, where both are the registered values.
- R9: When `rdEn` is 1, `rdData` shows the flags as they were before that edge, one cycle later. `rdData` holds its value between reads, and a read never changes any flag.
- R10: If software reads the flags and then writes the value it read back with the clear command, exactly the flags seen in the read are cleared. Events that arrive in between stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hwEvent | input | 8 | Per-flag event pulses, active high |
| wrEn | input | 1 | Write command valid |
| wrCmd | input | 2 | 00 enable, 01 clear, 10 set, 11 update |
| wrData | input | 8 | Bit selection, or the value byte for update |
| wrMask | input | 8 | Bit mask for update |
| rdEn | input | 1 | Read request |
| rdData | output | 8 | Flags captured at the last read |
| irq | output | 1 | OR of the enabled flags |

## Verification
The two functions that can land in the same cycle are a hardware event on a flag and a software clear or update aimed at that same flag. A read can also coincide with a write. The bench provokes these collisions on purpose with directed stimulus, and also by accident with random traffic. It then reads the flags back and compares them with a behavioural model in which the event always wins and a read returns the value from before the edge.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  typedef enum logic [1:0] {
    CMD_ENABLE = 2'b00,
    CMD_CLEAR  = 2'b01,
    CMD_SET    = 2'b10,
    CMD_UPDATE = 2'b11
  } cmd_e;

  typedef struct packed {
    logic loadEnable;
    logic clearFlags;
    logic setFlags;
    logic updateFlags;
    logic captureRead;
  } strobe_t;
endpackage

// File: rtl/irqf_ctrl.sv
module irqf_ctrl
  import irqf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] wrCmd,
  input  logic       rdEn,
  output strobe_t    strobes
);
  always_comb begin
    strobes = '0;
    strobes.captureRead = rdEn;
    if (wrEn) begin
      case (cmd_e'(wrCmd))
        CMD_ENABLE: strobes.loadEnable  = 1'b1;
        CMD_CLEAR:  strobes.clearFlags  = 1'b1;
        CMD_SET:    strobes.setFlags    = 1'b1;
        CMD_UPDATE: strobes.updateFlags = 1'b1;
        default:    strobes = strobes;
      endcase
    end
  end

  // R7: at most one write strobe per cycle, and one whenever a write is valid
  a_r7_one_write_strobe: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> $countones({strobes.loadEnable, strobes.clearFlags,
                         strobes.setFlags, strobes.updateFlags}) == 1);
endmodule

// File: rtl/irqf_datapath.sv
module irqf_datapath
  import irqf_pkg::*;
#(
  parameter int Width = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobes,
  input  logic [Width-1:0] hwEvent,
  input  logic [Width-1:0] wrData,
  input  logic [Width-1:0] wrMask,
  output logic [Width-1:0] rdData,
  output logic             irq
);
  logic [Width-1:0] flags;
  logic [Width-1:0] flagsNext;
  logic [Width-1:0] enableReg;

  for (genvar i = 0; i < Width; i++) begin : g_bit
    logic bitNext;
    always_comb begin
      bitNext = flags[i];
      if (strobes.clearFlags && wrData[i])  bitNext = 1'b0;
      if (strobes.setFlags && wrData[i])    bitNext = 1'b1;
      if (strobes.updateFlags && wrMask[i]) bitNext = wrData[i];
      if (hwEvent[i])                       bitNext = 1'b1;
    end
    assign flagsNext[i] = bitNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flags     <= '0;
      enableReg <= '0;
      rdData    <= '0;
    end else begin
      flags <= flagsNext;
      if (strobes.loadEnable)  enableReg <= wrData;
      if (strobes.captureRead) rdData    <= flags;
    end
  end

  assign irq = |(flags & enableReg);

  // R2: an event sets its flag at the next edge
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!rstN)
    (|hwEvent) |=> ((flags & $past(hwEvent)) == $past(hwEvent)));
  // R3: selected bits without an event are cleared
  a_r3_clear_bits: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearFlags |=> ((flags & $past(wrData) & ~$past(hwEvent)) == '0));
  // R4: selected bits are set
  a_r4_set_bits: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setFlags |=> ((flags & $past(wrData)) == $past(wrData)));
  // R5: unmasked bits keep their value unless an event fires
  a_r5_unmasked_kept: assert property (@(posedge clk) disable iff (!rstN)
    strobes.updateFlags |=>
      ((flags & ~$past(wrMask)) == (($past(flags) | $past(hwEvent)) & ~$past(wrMask))));
  // R7: enable writes leave flags alone
  a_r7_enable_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadEnable && hwEvent == '0) |=> $stable(flags));
  // R9: read returns prior flags with one cycle latency
  a_r9_read_latency: assert property (@(posedge clk) disable iff (!rstN)
    strobes.captureRead |=> (rdData == $past(flags)));
endmodule

// File: rtl/irq_flag_reg.sv
module irq_flag_reg
  import irqf_pkg::*;
#(
  parameter int Width = 8,
  localparam int CmdBits = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [Width-1:0]   hwEvent,
  input  logic               wrEn,
  input  logic [CmdBits-1:0] wrCmd,
  input  logic [Width-1:0]   wrData,
  input  logic [Width-1:0]   wrMask,
  input  logic               rdEn,
  output logic [Width-1:0]   rdData,
  output logic               irq
);
  strobe_t strobes;

  irqf_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrCmd   (wrCmd),
    .rdEn    (rdEn),
    .strobes (strobes)
  );

  irqf_datapath #(.Width(Width)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .hwEvent (hwEvent),
    .wrData  (wrData),
    .wrMask  (wrMask),
    .rdData  (rdData),
    .irq     (irq)
  );
endmodule

// File: tb/irq_flag_reg_tb.sv
module irq_flag_reg_tb;
  logic       clk = 0;
  logic       rstN = 0;
  logic [7:0] hwEvent = 0;
  logic       wrEn = 0;
  logic [1:0] wrCmd = 0;
  logic [7:0] wrData = 0;
  logic [7:0] wrMask = 0;
  logic       rdEn = 0;
  logic [7:0] rdData;
  logic       irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [7:0] mFlags = 0, mEn = 0, mRd = 0;

  always #5 clk = ~clk;

  irq_flag_reg u_dut (
    .clk(clk), .rstN(rstN), .hwEvent(hwEvent), .wrEn(wrEn), .wrCmd(wrCmd),
    .wrData(wrData), .wrMask(wrMask), .rdEn(rdEn), .rdData(rdData), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [7:0] ev, input logic we, input logic [1:0] cmd,
                     input logic [7:0] d, input logic [7:0] m, input logic re,
                     input string tag);
    logic [7:0] nf;
    hwEvent = ev; wrEn = we; wrCmd = cmd; wrData = d; wrMask = m; rdEn = re;
    @(posedge clk);
    nf = mFlags;
    if (re) mRd = mFlags;
    if (we) begin
      case (cmd)
        2'b00: mEn = d;
        2'b01: nf = nf & ~d;
        2'b10: nf = nf | d;
        default: nf = (nf & ~m) | (d & m);
      endcase
    end
    mFlags = nf | ev;
    @(negedge clk);
    hwEvent = 0; wrEn = 0; rdEn = 0;
    check({tag, " rdData"}, rdData, mRd);
    check({tag, " irq"}, irq, ((mFlags & mEn) != 0) ? 1 : 0);
  endtask

  task automatic rd(input string tag);
    cyc(8'h00, 0, 2'b00, 8'h00, 8'h00, 1, tag);
  endtask

  initial begin
    logic [7:0] seen;
    repeat (3) @(negedge clk);
    rstN = 1;
    check("R1 reset rdData", rdData, 0);
    check("R1 reset irq", irq, 0);
    rd("R1 flags after reset");
    check("R1 flags zero", rdData, 8'h00);
    // R2 sticky event
    cyc(8'h81, 0, 0, 0, 0, 0, "R2 event");
    cyc(8'h00, 0, 0, 0, 0, 0, "R2 idle");
    rd("R2 read");
    check("R2 sticky", rdData, 8'h81);
    // R4 set, R3 clear 0x24
    cyc(8'h00, 1, 2'b10, 8'hFF, 0, 0, "R4 set all");
    cyc(8'h00, 1, 2'b01, 8'h24, 0, 0, "R3 clear 2,5");
    rd("R3 read");
    check("R3 clear mask 0x24", rdData, 8'hDB);
    cyc(8'h00, 1, 2'b10, 8'h24, 0, 0, "R4 set 2,5");
    rd("R4 read");
    check("R4 set mask", rdData, 8'hFF);
    // R5 update
    cyc(8'h00, 1, 2'b11, 8'h05, 8'h0F, 0, "R5 update");
    rd("R5 read");
    check("R5 masked update", rdData, 8'hF5);
    // R6 event beats clear and update
    cyc(8'h10, 1, 2'b01, 8'hFF, 0, 0, "R6 clear vs event");
    rd("R6 read a");
    check("R6 event wins clear", rdData, 8'h10);
    cyc(8'h02, 1, 2'b11, 8'h00, 8'hFF, 0, "R6 update vs event");
    rd("R6 read b");
    check("R6 event wins update", rdData, 8'h02);
    // R7 enable write, R8 irq
    cyc(8'h00, 1, 2'b00, 8'h01, 0, 0, "R7 enable 01");
    check("R8 irq low, flag disabled", irq, 0);
    rd("R7 read");
    check("R7 flags untouched", rdData, 8'h02);
    cyc(8'h01, 0, 0, 0, 0, 0, "R8 event enabled");
    check("R8 irq high", irq, 1);
    // R9 read with same-cycle clear sees prior value
    cyc(8'h00, 1, 2'b01, 8'h01, 0, 1, "R9 read+clear");
    check("R9 pre-edge value", rdData, 8'h03);
    check("R8 irq drops", irq, 0);
    // R10 read, event, write back clear
    cyc(8'h00, 1, 2'b10, 8'h90, 0, 0, "R10 prep");
    rd("R10 read");
    seen = rdData;
    cyc(8'h40, 0, 0, 0, 0, 0, "R10 late event");
    cyc(8'h00, 1, 2'b01, seen, 0, 0, "R10 writeback");
    rd("R10 final");
    check("R10 only new event left", rdData, 8'h40);
    // random traffic against model
    for (int k = 0; k < 400; k++) begin
      cyc(($urandom % 4 == 0) ? 8'($urandom) : 8'h00, 1'($urandom), 2'($urandom),
          8'($urandom), 8'($urandom), 1'($urandom), "R9 random");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule